// File: doc/BRIEF.md
# Serial register access slave

This block lets an external host read or write one 16-bit control register per transaction over a four-wire serial port. The port has an active-low select, a serial clock, a data line into the slave and a data line out of it. While select is low the host sends an 8-bit command code, then an 8-bit register address, then 16 data bits, always most significant bit first. The slave samples its input on each rising serial-clock edge. During a read it returns the addressed register on its output, which changes after falling edges. The serial pins are oversampled by the system clock through synchronizers, so the serial clock must stay well below the system clock rate. At least four system clocks per serial half period are needed.

On the chip side a single-cycle read strobe fetches the register value from the bank combinationally. Writes leave through a valid/ready channel. A write request holds its address and data unchanged until the bank accepts it, and the bank may stall it for any number of cycles. A command-ready flag tells the host whether a new command may start. The flag is the logical AND of an external data-FIFO room signal and the slave's own state. It drops as soon as a write is committed and stays low until that write has been accepted and a fixed settling time has passed.

Top module: `sra_top`

## Requirements
- R1: A frame is 8 command bits, then 8 address bits, then 16 data bits, each field most significant bit first and each bit sampled on a rising serial-clock edge while select is low.
- R2: Command code 0x02 produces exactly one write request carrying the frame's address and data, raised only after the 16th data bit has been sampled.
- R3: Command code 0x03 pulses the read strobe once, with the frame's address, after the address byte. The returned value is shifted out on the serial output, most significant bit first. Bit 15 is valid before the first data rising edge and each later bit follows a falling edge.
- R4: Any command code other than 0x02 or 0x03 produces no write request and no read strobe, and the serial output stays 0 for the whole frame. The serial output is also 0 during write frames.
- R5: Select rising before the 32nd bit aborts the frame with no write. Select falling restarts the bit count from zero.
- R6: Bits clocked after the 32nd within one select-low period are ignored, so each frame touches exactly one register.
- R7: A pending write request keeps its valid flag, address and data unchanged until the cycle in which write-ready is high. A commit that arrives while a request is still pending is dropped.
- R8: Command-ready is low from the write commit until BUSY_CYCLES system clocks after the write handshake cycle, and high again after that.
- R9: Command-ready is low whenever the FIFO-room input is low.
- R10: The output enable is high exactly while select is low. While it is low the serial output is 0.
- R11: After reset there is no pending write, no read strobe and an all-zero output register, and command-ready follows FIFO-room.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Serial select, active low |
| sck | input | 1 | Serial clock, idle low |
| mosi | input | 1 | Serial data into the slave |
| miso | output | 1 | Serial data out of the slave |
| miso_oe | output | 1 | Output enable for miso |
| rd_en | output | 1 | One-cycle register read strobe |
| rd_addr | output | ADDR_W | Register read address |
| rd_data | input | DATA_W | Register value, valid in the rd_en cycle |
| wr_valid | output | 1 | Write request pending |
| wr_ready | input | 1 | Register bank accepts the write |
| wr_addr | output | ADDR_W | Write address |
| wr_data | output | DATA_W | Write data |
| fifo_room | input | 1 | External data FIFO can take more input |
| cmd_ready | output | 1 | Host may start a new command |

## Verification
The main function is driven by a list of frames that interleaves writes, reads of written and untouched addresses, and illegal command codes. This separates correct field order and bit order from shifted or reversed fields, and shows whether ignored codes leave the bank untouched. Extreme address and data values (0x00, 0xFF, 0xFFFF, 0x8001) expose truncated or swapped bits at the ends of each field. Directed frames then cover select dropped mid-frame, bits sent past the 32nd, a write stalled by the bank, the exact length of the busy window, and FIFO-room gating. These cases tell an early commit from a late one, and a drifting write request from a held one.

// File: rtl/sra_pkg.sv
package sra_pkg;
  localparam int CMD_W       = 8;
  localparam int DEF_ADDR_W  = 8;
  localparam int DEF_DATA_W  = 16;
  localparam logic [CMD_W-1:0] CMD_WRITE = 8'h02;
  localparam logic [CMD_W-1:0] CMD_READ  = 8'h03;
endpackage

// File: rtl/sra_sync.sv
module sra_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] lvl,
  output logic [W-1:0] rise,
  output logic [W-1:0] fall
);
  logic [W-1:0] stg [STAGES];
  logic [W-1:0] prev;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) stg[0] <= RST_VAL;
          else        stg[0] <= din;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) stg[s] <= RST_VAL;
          else        stg[s] <= stg[s-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) prev <= RST_VAL;
    else        prev <= stg[STAGES-1];

  assign lvl  = stg[STAGES-1];
  assign rise = lvl & ~prev;
  assign fall = ~lvl & prev;
endmodule

// File: rtl/sra_frame.sv
module sra_frame
  import sra_pkg::*;
#(
  parameter int ADDR_W = DEF_ADDR_W,
  parameter int DATA_W = DEF_DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_fall,
  input  logic              cs_lvl,
  input  logic              sck_rise,
  input  logic              mosi_lvl,
  output logic [CMD_W-1:0]  cmd_q,
  output logic [ADDR_W-1:0] addr_q,
  output logic [DATA_W-1:0] data_q,
  output logic              rd_load,
  output logic              wr_commit,
  output logic              shift_ok
);
  localparam int HDR_W   = CMD_W + ADDR_W;
  localparam int FRAME_W = HDR_W + DATA_W;
  localparam int CNT_W   = $clog2(FRAME_W + 1);

  logic [CNT_W-1:0]  cnt;
  logic              active;
  logic [DATA_W-2:0] sh;
  logic [DATA_W-1:0] nxt;

  assign nxt = {sh, mosi_lvl};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0; active <= 1'b0; sh <= '0;
      cmd_q <= '0; addr_q <= '0; data_q <= '0;
      rd_load <= 1'b0; wr_commit <= 1'b0;
    end else begin
      rd_load   <= 1'b0;
      wr_commit <= 1'b0;
      if (cs_fall) begin
        cnt    <= '0;
        active <= 1'b1;
      end else if (cs_lvl) begin
        active <= 1'b0;
      end else if (active && sck_rise && cnt != CNT_W'(FRAME_W)) begin
        sh  <= nxt[DATA_W-2:0];
        cnt <= cnt + 1'b1;
        if (cnt == CNT_W'(CMD_W - 1)) cmd_q <= nxt[CMD_W-1:0];
        if (cnt == CNT_W'(HDR_W - 1)) begin
          addr_q  <= nxt[ADDR_W-1:0];
          rd_load <= (cmd_q == CMD_READ);
        end
        if (cnt == CNT_W'(FRAME_W - 1)) begin
          data_q    <= nxt;
          wr_commit <= (cmd_q == CMD_WRITE);
        end
      end
    end
  end

  assign shift_ok = active && !cs_lvl && (cnt > CNT_W'(HDR_W));

  AST_CNT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    cs_fall |=> cnt == '0); // R5
  AST_CNT_SATURATE: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == CNT_W'(FRAME_W) && !cs_fall) |=> cnt == CNT_W'(FRAME_W)); // R6
endmodule

// File: rtl/sra_tx.sv
module sra_tx #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              load,
  input  logic [DATA_W-1:0] load_data,
  input  logic              shift_en,
  output logic              bit_out
);
  logic [DATA_W-1:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        sh <= '0;
    else if (clear)    sh <= '0;
    else if (load)     sh <= load_data;
    else if (shift_en) sh <= {sh[DATA_W-2:0], 1'b0};
  end

  assign bit_out = sh[DATA_W-1];
endmodule

// File: rtl/sra_busy.sv
module sra_busy #(
  parameter int CYCLES = 12
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy
);
  localparam int BW = $clog2(CYCLES + 1);
  logic [BW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (start)      cnt <= BW'(CYCLES);
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign busy = (cnt != '0);

  AST_BUSY_COUNTDOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt != '0 && !start) |=> cnt == $past(cnt) - BW'(1)); // R8
endmodule

// File: rtl/sra_top.sv
module sra_top
  import sra_pkg::*;
#(
  parameter int ADDR_W      = DEF_ADDR_W,
  parameter int DATA_W      = DEF_DATA_W,
  parameter int SYNC_STAGES = 2,
  parameter int BUSY_CYCLES = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              sck,
  input  logic              mosi,
  output logic              miso,
  output logic              miso_oe,
  output logic              rd_en,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic [DATA_W-1:0] rd_data,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  input  logic              fifo_room,
  output logic              cmd_ready
);
  logic [2:0] s_lvl, s_rise, s_fall;
  logic [CMD_W-1:0]  cmd_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;
  logic rd_load, wr_commit, shift_ok, tx_bit, busy, wr_fire;
  logic unused_edges;

  sra_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk(clk), .rst_n(rst_n), .din({cs_n, sck, mosi}),
    .lvl(s_lvl), .rise(s_rise), .fall(s_fall));

  assign unused_edges = ^{s_rise[2], s_rise[0], s_fall[0], s_lvl[1]};

  sra_frame #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_frame (
    .clk(clk), .rst_n(rst_n), .cs_fall(s_fall[2]), .cs_lvl(s_lvl[2]),
    .sck_rise(s_rise[1]), .mosi_lvl(s_lvl[0]),
    .cmd_q(cmd_q), .addr_q(addr_q), .data_q(data_q),
    .rd_load(rd_load), .wr_commit(wr_commit), .shift_ok(shift_ok));

  sra_tx #(.DATA_W(DATA_W)) u_tx (
    .clk(clk), .rst_n(rst_n), .clear(s_fall[2]), .load(rd_load),
    .load_data(rd_data), .shift_en(s_fall[1] && shift_ok), .bit_out(tx_bit));

  assign rd_en   = rd_load;
  assign rd_addr = addr_q;

  assign wr_fire = wr_valid && wr_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_valid <= 1'b0; wr_addr <= '0; wr_data <= '0;
    end else if (wr_commit && !wr_valid) begin
      wr_valid <= 1'b1; wr_addr <= addr_q; wr_data <= data_q;
    end else if (wr_fire) begin
      wr_valid <= 1'b0;
    end
  end

  sra_busy #(.CYCLES(BUSY_CYCLES)) u_busy (
    .clk(clk), .rst_n(rst_n), .start(wr_fire), .busy(busy));

  assign cmd_ready = fifo_room && !wr_valid && !busy;
  assign miso_oe   = !cs_n;
  assign miso      = miso_oe && tx_bit;

  AST_WR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_addr) && $stable(wr_data))); // R7
  AST_WR_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_valid) |-> $past(cmd_q) == CMD_WRITE); // R2
  AST_RD_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |-> cmd_q == CMD_READ); // R3
  AST_RD_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> !rd_en); // R3
endmodule

// File: tb/sra_top_tb.sv
module sra_top_tb;
  localparam int BUSY = 12;
  localparam int HALF = 8;
  localparam int NVEC = 12;
  // {cmd, addr, wdata, expected read word}
  localparam logic [47:0] VEC [NVEC] = '{
    {8'h02, 8'h05, 16'hA55A, 16'h0000},
    {8'h03, 8'h05, 16'h0000, 16'hA55A},
    {8'h02, 8'hFF, 16'h8001, 16'h0000},
    {8'h03, 8'hFF, 16'h0000, 16'h8001},
    {8'h01, 8'h05, 16'h1234, 16'h0000},
    {8'h03, 8'h05, 16'h0000, 16'hA55A},
    {8'h03, 8'h3C, 16'h0000, 16'h3CC3},
    {8'h02, 8'h00, 16'hFFFF, 16'h0000},
    {8'h03, 8'h00, 16'h0000, 16'hFFFF},
    {8'hFF, 8'h00, 16'h0000, 16'h0000},
    {8'h03, 8'h00, 16'h0000, 16'hFFFF},
    {8'h03, 8'h81, 16'h0000, 16'h817E}
  };

  logic clk = 0, rst_n = 0;
  logic cs_n = 1, sck = 0, mosi = 0;
  logic miso, miso_oe, rd_en, wr_valid, cmd_ready;
  logic wr_ready = 1, fifo_room = 1;
  logic [7:0] rd_addr, wr_addr;
  logic [15:0] rd_data, wr_data;
  logic [15:0] mem [256];
  int checks = 0, failures = 0;
  int wr_cnt = 0, rd_cnt = 0;
  logic [7:0] last_a;
  logic [15:0] last_d;

  always #4 clk = ~clk;

  sra_top #(.BUSY_CYCLES(BUSY)) u_dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .mosi(mosi),
    .miso(miso), .miso_oe(miso_oe), .rd_en(rd_en), .rd_addr(rd_addr),
    .rd_data(rd_data), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_addr(wr_addr), .wr_data(wr_data), .fifo_room(fifo_room),
    .cmd_ready(cmd_ready));

  assign rd_data = mem[rd_addr];

  initial for (int i = 0; i < 256; i++) mem[i] = {i[7:0], ~i[7:0]};

  always @(posedge clk) begin
    if (rst_n && wr_valid && wr_ready) begin
      wr_cnt++;
      last_a = wr_addr;
      last_d = wr_data;
      mem[wr_addr] <= wr_data;
    end
    if (rst_n && rd_en) rd_cnt++;
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic xfer(input logic [7:0] c, input logic [7:0] a, input logic [15:0] d,
                      input int nbits, output logic [15:0] rx);
    logic [39:0] bits;
    bits = {c, a, d, 8'hFF};
    rx = '0;
    cs_n = 0;
    repeat (HALF) @(negedge clk);
    for (int i = 0; i < nbits; i++) begin
      mosi = bits[39-i];
      repeat (HALF) @(negedge clk);
      if (i >= 16 && i < 32) rx = {rx[14:0], miso};
      sck = 1;
      repeat (HALF) @(negedge clk);
      sck = 0;
    end
    repeat (HALF) @(negedge clk);
    cs_n = 1;
    repeat (HALF) @(negedge clk);
  endtask

  task automatic wait_ready();
    for (int i = 0; i < 200 && !cmd_ready; i++) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [15:0] rx;
    int n;
    repeat (3) @(negedge clk);
    // R11 reset state
    check(!wr_valid && !rd_en && cmd_ready, "R11", {wr_valid, rd_en, cmd_ready}, 3'b001);
    rst_n = 1;
    repeat (4) @(negedge clk);
    check(!miso_oe && !miso, "R10", {miso_oe, miso}, 2'b00);

    // vector table: R1 R2 R3 R4
    for (int v = 0; v < NVEC; v++) begin
      logic [7:0] c, a;
      logic [15:0] d, e;
      int w0, r0;
      {c, a, d, e} = VEC[v];
      w0 = wr_cnt; r0 = rd_cnt;
      xfer(c, a, d, 32, rx);
      repeat (4) @(negedge clk);
      if (c == 8'h02) begin
        check(wr_cnt == w0 + 1 && last_a == a && last_d == d, "R2",
              {last_a, last_d}, {a, d});
        check(rx == 16'h0, "R4", rx, 0);
      end else if (c == 8'h03) begin
        check(rx == e, "R3", rx, e);
        check(rd_cnt == r0 + 1 && wr_cnt == w0, "R1", rd_cnt - r0, 1);
      end else begin
        check(wr_cnt == w0 && rd_cnt == r0 && rx == 16'h0, "R4",
              {wr_cnt - w0, rx}, 0);
      end
      wait_ready();
    end

    // R5 abort mid-frame, then restart
    n = wr_cnt;
    xfer(8'h02, 8'h05, 16'h0BAD, 20, rx);
    repeat (30) @(negedge clk);
    check(wr_cnt == n, "R5", wr_cnt - n, 0);
    xfer(8'h03, 8'h05, 16'h0, 32, rx);
    check(rx == 16'hA55A, "R5", rx, 16'hA55A);

    // R6 extra bits ignored
    n = wr_cnt;
    xfer(8'h02, 8'h10, 16'h1357, 40, rx);
    repeat (4) @(negedge clk);
    check(wr_cnt == n + 1 && last_d == 16'h1357 && last_a == 8'h10, "R6",
          {wr_cnt - n, last_d}, {32'd1, 16'h1357});
    wait_ready();

    // R10 enable while select low
    cs_n = 0;
    @(negedge clk);
    check(miso_oe, "R10", miso_oe, 1);
    cs_n = 1;
    repeat (HALF) @(negedge clk);
    check(!miso_oe && !miso, "R10", {miso_oe, miso}, 0);

    // R7/R8 stalled write and busy window
    wr_ready = 0;
    xfer(8'h02, 8'h22, 16'hC0DE, 32, rx);
    check(wr_valid && !cmd_ready, "R8", {wr_valid, cmd_ready}, 2'b10);
    repeat (5) @(negedge clk);
    check(wr_valid && wr_addr == 8'h22 && wr_data == 16'hC0DE, "R7",
          {wr_addr, wr_data}, {8'h22, 16'hC0DE});
    // second frame while pending is dropped
    xfer(8'h02, 8'h23, 16'h1111, 32, rx);
    check(wr_valid && wr_addr == 8'h22 && wr_data == 16'hC0DE, "R7",
          {wr_addr, wr_data}, {8'h22, 16'hC0DE});
    wr_ready = 1;
    n = 0;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      n++;
      if (cmd_ready) break;
    end
    check(n == BUSY + 1, "R8", n, BUSY + 1);
    check(mem[8'h23] == 16'h23DC, "R7", mem[8'h23], 16'h23DC);

    // R9 FIFO room gating
    fifo_room = 0;
    @(negedge clk);
    check(!cmd_ready, "R9", cmd_ready, 0);
    fifo_room = 1;
    @(negedge clk);
    check(cmd_ready, "R9", cmd_ready, 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule